// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

The block moves bytes between time slots of a set of TDM streams. Each frame carries STREAMS x CHANNELS slots, with one slot handled per clock cycle. A frame-sync input aligns the slot counter. Every incoming byte is written into a frame-banked data memory. For each outgoing slot, a connection memory holds a small control field (the high section) and a byte (the low section). The control field selects switched data or a processor-sourced constant message byte, and it sets the slot's driver enable.

Switched data is fetched from the bank written during the previous frame, so every switched path has a constant one-frame delay. A control register holds three bits. One sets which connection section processor writes reach. One is a broadcast bit that forces every slot into message mode with its driver enabled. One is a link-expansion bit that changes how slot numbers map onto output stream and channel. An external output-enable input overrides everything and silences all slots. Each slot's result is presented for one cycle as a byte with valid, output-enable, slot, stream and channel tags.

Top module: `tsi_switch`

## Requirements
- R1: The current slot is 0 in any cycle where `fsync` is 1. Otherwise the slot is the previous slot plus one, and it wraps from SLOTS-1 to 0. Every slot 0 begins a new frame, whether `fsync` forced it or the counter wrapped to it.
- R2: A switched slot outputs the byte received in its source slot during the previous frame. This gives a constant one-frame delay.
- R3: In switch mode, only bits [SLOT_W-1:0] of the slot's low connection byte are used. They name the source slot, encoded as channel*STREAMS+stream, so the stream sits in the least significant bits. The higher bits are ignored.
- R4: When high-section bit 2 is 1, the slot outputs its low connection byte. The same byte repeats every frame until it is rewritten.
- R5: High-section bit 0 enables the slot's driver. When the driver is disabled, `tx_oe` is 0 and `tx_byte` is 0. The other high-section bits are ignored.
- R6: Control bit 1 (broadcast) makes every slot behave as if high-section bits 2 and 0 were both 1, whatever values are stored.
- R7: When `oe_pin` is 0, `tx_oe` and `tx_byte` are 0 for that slot. This overrides broadcast and all per-slot bits.
- R8: A write with `cpu_ctrl`=1 loads the control register from `cpu_wdata[2:0]` (bit 0 section select, bit 1 broadcast, bit 2 link mode). A write with `cpu_ctrl`=0 goes to location `cpu_addr`: the high section when section select is 1, the low section when it is 0.
- R9: When a processor write reaches the location being read in the same cycle, that slot uses the old contents. The new value takes effect from the next frame.
- R10: With link mode off, `tx_stream` = slot mod STREAMS and `tx_chan` = slot / STREAMS. With link mode on, slots below EXP0_SLOTS map to stream 0 with channel = slot. The remaining slots map to stream 1 with channel = slot - EXP0_SLOTS.
- R11: Outputs for the slot handled in cycle t appear in cycle t+1. After reset, `tx_valid` and `tx_oe` are 0 and all high-section bits are 0. `tx_valid` rises with the first frame-sync slot and then stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, forces slot 0 |
| rx_byte | input | DW | Incoming byte for the current slot |
| oe_pin | input | 1 | Global output enable, active high |
| cpu_we | input | 1 | Processor write strobe |
| cpu_ctrl | input | 1 | Write targets the control register |
| cpu_addr | input | SLOT_W | Connection location |
| cpu_wdata | input | DW | Write data |
| tx_byte | output | DW | Outgoing byte |
| tx_valid | output | 1 | Frame alignment established |
| tx_oe | output | 1 | Driver enable for this slot |
| tx_slot | output | SLOT_W | Slot index of this output |
| tx_stream | output | STRM_W | Output stream of this slot |
| tx_chan | output | SLOT_W | Output channel of this slot |

## Verification
The hardest case to reach from the ports is a processor write landing on the very connection location being read in that cycle. The bench reaches it with a frame where the write address follows the slot counter, so every location is hit exactly in its own slot, and it then checks the old routing in that frame and the new routing in the next. Short frames cut off by an early `fsync` and a frame with no `fsync` at all test the counter's realignment. In those frames, source bytes that were never written in the previous frame are tracked and left unchecked.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int CTL_SEL_BIT  = 0;
  localparam int CTL_BCST_BIT = 1;
  localparam int CTL_LINK_BIT = 2;
  localparam int CMH_EN_BIT   = 0;
  localparam int CMH_MSG_BIT  = 2;

  typedef struct packed {
    logic link;
    logic bcst;
    logic sel;
  } ctl_t;

  typedef struct packed {
    logic msg;
    logic en;
  } cmh_t;

  typedef enum logic {
    SEC_LOW  = 1'b0,
    SEC_HIGH = 1'b1
  } sec_e;
endpackage

// File: rtl/tsi_rst_sync.sv
module tsi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              wr_bank,
  output logic              aligned
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              bank_q, bank_d;
  logic              seen_q, seen_d;

  always_comb begin
    cur_slot = fsync ? '0 : cnt_q;
    cnt_d    = (cur_slot == LAST) ? '0 : cur_slot + 1'b1;
    bank_d   = (cur_slot == '0) ? ~bank_q : bank_q;
    seen_d   = seen_q | fsync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bank_q <= bank_d;
      seen_q <= seen_d;
    end
  end

  assign wr_bank = bank_d;
  assign aligned = seen_d;
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int DW     = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic              cpu_ctrl,
  input  logic [SLOT_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic [SLOT_W-1:0] rd_slot,
  output cmh_t              rd_hi,
  output logic [DW-1:0]     rd_lo,
  output ctl_t              ctl
);
  ctl_t ctl_q, ctl_d;
  logic hi_we, lo_we;
  cmh_t          hi_arr [SLOTS];
  logic [DW-1:0] lo_arr [SLOTS];

  always_comb begin
    ctl_d = ctl_q;
    if (cpu_we && cpu_ctrl) begin
      ctl_d.sel  = cpu_wdata[CTL_SEL_BIT];
      ctl_d.bcst = cpu_wdata[CTL_BCST_BIT];
      ctl_d.link = cpu_wdata[CTL_LINK_BIT];
    end
    hi_we = cpu_we && !cpu_ctrl && (sec_e'(ctl_q.sel) == SEC_HIGH);
    lo_we = cpu_we && !cpu_ctrl && (sec_e'(ctl_q.sel) == SEC_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_loc
    logic hit;
    cmh_t hi_q;
    logic [DW-1:0] lo_q;

    assign hit = (cpu_addr == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
      end else if (hi_we && hit) begin
        hi_q.msg <= cpu_wdata[CMH_MSG_BIT];
        hi_q.en  <= cpu_wdata[CMH_EN_BIT];
      end
    end

    always_ff @(posedge clk) begin
      if (lo_we && hit) lo_q <= cpu_wdata;
    end

    assign hi_arr[g] = hi_q;
    assign lo_arr[g] = lo_q;
  end

  assign rd_hi = hi_arr[rd_slot];
  assign rd_lo = lo_arr[rd_slot];
  assign ctl   = ctl_q;
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int SLOTS  = 16,
  parameter int DW     = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              wr_bank,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DW-1:0]     wr_data,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [SLOTS];
    logic          wr_en;

    assign wr_en = (wr_bank == 1'(b));

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_slot] <= wr_data;
    end

    assign bank_rd[b] = mem[rd_addr];
  end

  assign rd_data = bank_rd[~wr_bank];
endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage
  import tsi_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SLOT_W    = 4,
  parameter int STRM_W    = 1,
  parameter int EXP0_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              aligned,
  input  logic              oe_pin,
  input  ctl_t              ctl,
  input  cmh_t              hi,
  input  logic [DW-1:0]     lo,
  input  logic [DW-1:0]     dm_byte,
  output logic [DW-1:0]     tx_byte,
  output logic              tx_valid,
  output logic              tx_oe,
  output logic [SLOT_W-1:0] tx_slot,
  output logic [STRM_W-1:0] tx_stream,
  output logic [SLOT_W-1:0] tx_chan
);
  localparam logic [SLOT_W-1:0] SPLIT = SLOT_W'(EXP0_SLOTS);

  logic              msg_eff, en_eff;
  logic [DW-1:0]     byte_d;
  logic [STRM_W-1:0] strm_d;
  logic [SLOT_W-1:0] chan_d;

  always_comb begin
    msg_eff = ctl.bcst | hi.msg;
    en_eff  = oe_pin & (ctl.bcst | hi.en);
    if (!en_eff)      byte_d = '0;
    else if (msg_eff) byte_d = lo;
    else              byte_d = dm_byte;

    if (ctl.link) begin
      if (slot < SPLIT) begin
        strm_d = '0;
        chan_d = slot;
      end else begin
        strm_d = STRM_W'(1);
        chan_d = slot - SPLIT;
      end
    end else begin
      strm_d = slot[STRM_W-1:0];
      chan_d = slot >> STRM_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte   <= '0;
      tx_valid  <= 1'b0;
      tx_oe     <= 1'b0;
      tx_slot   <= '0;
      tx_stream <= '0;
      tx_chan   <= '0;
    end else begin
      tx_byte   <= byte_d;
      tx_valid  <= aligned;
      tx_oe     <= en_eff;
      tx_slot   <= slot;
      tx_stream <= strm_d;
      tx_chan   <= chan_d;
    end
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int STREAMS    = 2,
  parameter int CHANNELS   = 8,
  parameter int DW         = 8,
  parameter int EXP0_SLOTS = 4,
  localparam int SLOTS     = STREAMS * CHANNELS,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int STRM_W    = $clog2(STREAMS)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              fsync,
  input  logic [DW-1:0]     rx_byte,
  input  logic              oe_pin,
  input  logic              cpu_we,
  input  logic              cpu_ctrl,
  input  logic [SLOT_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     tx_byte,
  output logic              tx_valid,
  output logic              tx_oe,
  output logic [SLOT_W-1:0] tx_slot,
  output logic [STRM_W-1:0] tx_stream,
  output logic [SLOT_W-1:0] tx_chan
);
  logic              rst_n;
  logic [SLOT_W-1:0] cur_slot;
  logic              wr_bank, aligned;
  cmh_t              cm_hi;
  logic [DW-1:0]     cm_lo, dm_byte;
  ctl_t              ctl_q;

  tsi_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  tsi_slot_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .cur_slot(cur_slot), .wr_bank(wr_bank), .aligned(aligned)
  );

  tsi_conn_mem #(.SLOTS(SLOTS), .DW(DW), .SLOT_W(SLOT_W)) u_cm (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_ctrl(cpu_ctrl),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rd_slot(cur_slot),
    .rd_hi(cm_hi), .rd_lo(cm_lo), .ctl(ctl_q)
  );

  tsi_data_mem #(.SLOTS(SLOTS), .DW(DW), .SLOT_W(SLOT_W)) u_dm (
    .clk(clk), .wr_bank(wr_bank), .wr_slot(cur_slot), .wr_data(rx_byte),
    .rd_addr(cm_lo[SLOT_W-1:0]), .rd_data(dm_byte)
  );

  tsi_out_stage #(.DW(DW), .SLOT_W(SLOT_W), .STRM_W(STRM_W),
                  .EXP0_SLOTS(EXP0_SLOTS)) u_out (
    .clk(clk), .rst_n(rst_n), .slot(cur_slot), .aligned(aligned),
    .oe_pin(oe_pin), .ctl(ctl_q), .hi(cm_hi), .lo(cm_lo), .dm_byte(dm_byte),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_oe(tx_oe),
    .tx_slot(tx_slot), .tx_stream(tx_stream), .tx_chan(tx_chan)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int DW         = 8,
  parameter int SLOTS      = 16,
  parameter int SLOT_W     = 4,
  parameter int STRM_W     = 1,
  parameter int EXP0_SLOTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fsync,
  input logic              oe_pin,
  input logic              bcst,
  input logic              link,
  input logic [DW-1:0]     tx_byte,
  input logic              tx_valid,
  input logic              tx_oe,
  input logic [SLOT_W-1:0] tx_slot,
  input logic [STRM_W-1:0] tx_stream
);
  // R1
  fsync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (tx_slot == '0));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !fsync) |=>
      (tx_slot == (($past(tx_slot) == SLOT_W'(SLOTS - 1)) ? '0 : $past(tx_slot) + 1'b1)));

  // R5
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> (tx_byte == '0));

  // R6
  bcst_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcst && oe_pin) |=> tx_oe);

  // R7
  pin_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_pin |=> (!tx_oe && tx_byte == '0));

  // R10
  link_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link |=> ((tx_slot < SLOT_W'(EXP0_SLOTS)) == (tx_stream == '0)));

  // R11
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_valid);
endmodule

bind tsi_switch tsi_switch_chk #(
  .DW(DW), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .STRM_W(STRM_W), .EXP0_SLOTS(EXP0_SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .oe_pin(oe_pin),
  .bcst(ctl_q.bcst), .link(ctl_q.link),
  .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_oe(tx_oe),
  .tx_slot(tx_slot), .tx_stream(tx_stream)
);

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int STREAMS = 2, CHANNELS = 8, DW = 8, EXP0 = 4;
  localparam int S = STREAMS * CHANNELS, SW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic arst_n, fsync, oe_pin, cpu_we, cpu_ctrl;
  logic [DW-1:0] rx_byte, cpu_wdata, tx_byte;
  logic [SW-1:0] cpu_addr, tx_slot, tx_chan;
  logic tx_valid, tx_oe;
  logic [0:0] tx_stream;

  tsi_switch #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .DW(DW), .EXP0_SLOTS(EXP0)) dut (
    .clk(clk), .arst_n(arst_n), .fsync(fsync), .rx_byte(rx_byte), .oe_pin(oe_pin),
    .cpu_we(cpu_we), .cpu_ctrl(cpu_ctrl), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_oe(tx_oe), .tx_slot(tx_slot),
    .tx_stream(tx_stream), .tx_chan(tx_chan)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // bench model, built from the requirements
  logic [7:0] m_lo [S];
  bit m_lok [S], m_msg [S], m_en [S];
  bit g_bcst, g_link, g_sel, aligned;
  logic [7:0] curf [S], prevf [S];
  bit curk [S], prevk [S];
  int cnt;

  bit have, e_valid, e_oe, e_dchk;
  logic [7:0] e_data;
  int e_slot, e_stream, e_chan;
  string e_req;

  function automatic logic [7:0] lo_init(int a);
    return (a % 3 == 0) ? 8'(8'hC0 ^ (a * 9)) : 8'(8'h30 | ((a * 5 + 3) % S));
  endfunction

  function automatic logic [7:0] lo_new(int a);
    return (a % 3 == 0) ? 8'(8'h11 * a + 1) : 8'(8'h40 | ((a * 3 + 1) % S));
  endfunction

  task automatic compare();
    bit bad;
    if (!have) return;
    vectors++;
    bad = (tx_valid !== e_valid) || (tx_oe !== e_oe) || (int'(tx_slot) != e_slot) ||
          (int'(tx_stream) != e_stream) || (int'(tx_chan) != e_chan) ||
          (e_dchk && tx_byte !== e_data);
    if (bad) begin
      miscompares++;
      $display("FAIL %s slot %0d: got valid=%0b oe=%0b data=%h slot=%0d stream=%0d chan=%0d, expected valid=%0b oe=%0b data=%h slot=%0d stream=%0d chan=%0d",
               e_req, e_slot, tx_valid, tx_oe, tx_byte, tx_slot, tx_stream, tx_chan,
               e_valid, e_oe, e_data, e_slot, e_stream, e_chan);
    end
  endtask

  task automatic step(bit fs, logic [7:0] din, bit oe, bit we, bit ctl,
                      int addr, logic [7:0] wd, string req);
    int m, src;
    bit msg, en;
    @(negedge clk);
    compare();
    fsync = fs; rx_byte = din; oe_pin = oe; cpu_we = we; cpu_ctrl = ctl;
    cpu_addr = SW'(addr); cpu_wdata = wd;
    m = fs ? 0 : cnt;
    if (m == 0) begin
      for (int i = 0; i < S; i++) begin
        prevf[i] = curf[i]; prevk[i] = curk[i]; curk[i] = 0;
      end
    end
    aligned = aligned | fs;
    // expected values use the connection state before this cycle's write (R9)
    msg = g_bcst | m_msg[m];
    en  = oe & (g_bcst | m_en[m]);
    src = int'(m_lo[m][SW-1:0]);
    e_valid = aligned; e_oe = en; e_slot = m; e_req = req;
    if (!en) begin
      e_data = 8'h00; e_dchk = 1;
    end else if (msg) begin
      e_data = m_lo[m]; e_dchk = m_lok[m];
    end else begin
      e_data = prevf[src]; e_dchk = m_lok[m] && prevk[src];
    end
    if (g_link) begin
      e_stream = (m < EXP0) ? 0 : 1; e_chan = (m < EXP0) ? m : m - EXP0;
    end else begin
      e_stream = m % STREAMS; e_chan = m / STREAMS;
    end
    curf[m] = din; curk[m] = 1;
    if (we && ctl) begin
      g_sel = wd[0]; g_bcst = wd[1]; g_link = wd[2];
    end else if (we && g_sel) begin
      m_msg[addr] = wd[2]; m_en[addr] = wd[0];
    end else if (we) begin
      m_lo[addr] = wd; m_lok[addr] = 1;
    end
    cnt = (m + 1) % S;
    have = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < S; i++) begin
      m_lo[i] = 0; m_lok[i] = 0; m_msg[i] = 0; m_en[i] = 0;
      curf[i] = 0; prevf[i] = 0; curk[i] = 0; prevk[i] = 0;
    end
    g_bcst = 0; g_link = 0; g_sel = 0; aligned = 0; cnt = 0; have = 0;
    arst_n = 0; fsync = 0; rx_byte = 0; oe_pin = 1; cpu_we = 0; cpu_ctrl = 0;
    cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(posedge clk);
    arst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state: no valid output and no driver before the first frame sync
    vectors++;
    if (tx_valid !== 1'b0 || tx_oe !== 1'b0) begin
      miscompares++;
      $display("FAIL R11 reset: got valid=%0b oe=%0b, expected valid=0 oe=0", tx_valid, tx_oe);
    end

    for (int f = 0; f < 17; f++) begin
      int len = (f == 13) ? 10 : S;
      for (int s = 0; s < len; s++) begin
        bit we = 0, ctl = 0, oe = 1, fs;
        int addr = 0;
        logic [7:0] wd = 8'h00;
        logic [7:0] din = 8'((f * 29 + s * 7 + 3) & 8'hFF);
        string req = "R2";
        fs = (s == 0) && (f != 15);
        case (f)
          0:  begin req = "R8"; if (s == 0) begin we = 1; ctl = 1; wd = 8'h01; end end
          1:  begin req = "R8"; we = 1; addr = s;
                wd = 8'h82 | ((s % 3 == 0) ? 8'h04 : 8'h00) | ((s % 4 != 1) ? 8'h01 : 8'h00); end
          2:  begin req = "R8"; if (s == 0) begin we = 1; ctl = 1; wd = 8'h00; end end
          3:  begin req = "R8"; we = 1; addr = (s + 1) % S; wd = lo_init(addr); end
          4:  req = "R3";
          5:  begin req = "R5"; oe = (s % 3 != 2); end
          6:  req = "R4";
          7:  begin req = "R6"; if (s == 0) begin we = 1; ctl = 1; wd = 8'h02; end end
          8:  begin req = "R7"; oe = !(s >= 4 && s < 8); end
          9:  begin req = "R10"; if (s == 0) begin we = 1; ctl = 1; wd = 8'h04; end end
          10: req = "R10";
          11: begin req = "R9"; we = 1; addr = s; wd = lo_new(s); end
          12: req = "R2";
          13: req = "R1";
          14: begin req = "R1"; if (s == 0) begin we = 1; ctl = 1; wd = 8'h00; end end
          15: req = "R1";
          default: req = "R11";
        endcase
        step(fs, din, oe, we, ctl, addr, wd, req);
      end
    end
    step(0, 8'h00, 1, 0, 0, 0, 8'h00, "R11");
    @(negedge clk);
    compare();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule